// File: doc/BRIEF.md
# Microcoded Two-Bus Datapath Core

This block is the data side of a microprogrammed processor. A horizontal microinstruction sets its control fields, which change every cycle. An encoded select field places one source on the B bus. The sources are a bank of general registers, a word from the memory side, or a fetched byte widened with zero or sign extension. The ALU always takes its left operand from a dedicated holding register and its right operand from the B bus. Its result passes through a small shifter to form the C bus.

A one-hot write mask names every register that stores the C-bus value at the next rising edge. Any mix of general registers and the holding register can be written together. A register can be read and rewritten in the same cycle, so an increment such as `x = x + 1` takes one microinstruction. Two flags, negative and zero, are taken from the unshifted ALU result. The sequencer outside the block uses them for conditional branches.

Sequencing and the memory bus are handled by neighbouring blocks. The memory word and the fetched byte arrive here only as inputs.

Top module: `ubus_datapath`

## Requirements
- R1: After reset every general register and the holding register read as zero.
- R2: `b_sel` values 0 to NGEN-1 place that general register on the B bus. Value NGEN places `mem_word`. NGEN+1 places `mem_byte` zero-extended and NGEN+2 places `mem_byte` sign-extended. Every higher value places zero.
- R3: `alu_ctl` is {F1,F0,ENA,ENB,INVA,INC} from bit 5 down to bit 0. F1:F0 selects 00 = A AND B, 01 = A OR B, 10 = NOT B and 11 = A + B.
- R4: INVA complements the gated A operand. INC adds a carry-in of one in the add function only, so ENA=1, INVA=1, INC=1, ENB=0 with add yields the negated holding register.
- R5: A clear ENA forces operand A to zero. A clear ENB forces operand B to zero.
- R6: `shift_ctl` 00 passes the ALU result to the C bus unchanged. 01 shifts it right arithmetically by one, 10 shifts it left logically by eight, and 11 behaves as 00.
- R7: `wr_mask` bit i (i < NGEN) loads general register i from the C bus at the rising edge. Bit NGEN loads the holding register. Registers whose bit is clear keep their value.
- R8: A register selected on the B bus and set in the write mask in the same cycle stores the value computed from its old contents.
- R9: `n_flag` equals the most significant bit of the ALU result before the shifter.
- R10: `z_flag` is one exactly when the ALU result before the shifter is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alu_ctl | input | 6 | {F1,F0,ENA,ENB,INVA,INC} |
| shift_ctl | input | 2 | Shifter code |
| wr_mask | input | NGEN+1 | One-hot-per-register C-bus write mask; top bit is the holding register |
| b_sel | input | BSW | Encoded B-bus source |
| mem_word | input | W | Word delivered by the memory block |
| mem_byte | input | 8 | Fetched byte delivered by the memory block |
| c_bus | output | W | Shifter output, the value written this cycle |
| n_flag | output | 1 | ALU result negative |
| z_flag | output | 1 | ALU result zero |

## Verification
The bench builds the block with W = 32 and NGEN = 8. This makes `b_sel` four bits wide, so the unused codes 11 to 15 can be driven and checked for a zero B bus. With a 32-bit word, the byte sign-extension and the eight-place left shift are exercised on real upper bits. The nine-bit mask lets random cycles write several general registers and the holding register at once while the bench model tracks all of them.

// File: rtl/ubd_pkg.sv
package ubd_pkg;

    typedef enum logic [1:0] {
        FN_AND  = 2'b00,
        FN_OR   = 2'b01,
        FN_NOTB = 2'b10,
        FN_ADD  = 2'b11
    } alu_fn_e;

    typedef enum logic [1:0] {
        SH_NONE = 2'b00,
        SH_SRA1 = 2'b01,
        SH_SLL8 = 2'b10,
        SH_RSVD = 2'b11
    } shift_e;

    typedef struct packed {
        alu_fn_e fn;
        logic    ena;
        logic    enb;
        logic    inva;
        logic    inc;
    } alu_ctl_t;

endpackage

// File: rtl/ubd_bsel.sv
module ubd_bsel #(
    parameter int W    = 32,
    parameter int NGEN = 8,
    parameter int BSW  = $clog2(NGEN + 3),
    parameter int IDXW = $clog2(NGEN)
) (
    input  logic [NGEN-1:0][W-1:0] gen,
    input  logic [BSW-1:0]         b_sel,
    input  logic [W-1:0]           mem_word,
    input  logic [7:0]             mem_byte,
    output logic [W-1:0]           b_bus
);
    localparam logic [BSW-1:0] SEL_WORD = BSW'(NGEN);
    localparam logic [BSW-1:0] SEL_BYTU = BSW'(NGEN + 1);
    localparam logic [BSW-1:0] SEL_BYTS = BSW'(NGEN + 2);

    always_comb begin
        b_bus = '0;
        if (b_sel < SEL_WORD) begin
            b_bus = gen[b_sel[IDXW-1:0]];
        end else if (b_sel == SEL_WORD) begin
            b_bus = mem_word;
        end else if (b_sel == SEL_BYTU) begin
            b_bus = {{(W-8){1'b0}}, mem_byte};
        end else if (b_sel == SEL_BYTS) begin
            b_bus = {{(W-8){mem_byte[7]}}, mem_byte};
        end
    end
endmodule

// File: rtl/ubd_alu.sv
module ubd_alu
    import ubd_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_ctl_t       ctl,
    input  logic [W-1:0]   a_in,
    input  logic [W-1:0]   b_in,
    output logic [W-1:0]   res,
    output logic           neg,
    output logic           zero
);
    logic [W-1:0] a_g;
    logic [W-1:0] b_g;

    always_comb begin
        a_g = ctl.ena ? a_in : '0;
        if (ctl.inva) a_g = ~a_g;
        b_g = ctl.enb ? b_in : '0;
        unique case (ctl.fn)
            FN_AND:  res = a_g & b_g;
            FN_OR:   res = a_g | b_g;
            FN_NOTB: res = ~b_g;
            default: res = a_g + b_g + W'(ctl.inc);
        endcase
        neg  = res[W-1];
        zero = (res == '0);
    end
endmodule

// File: rtl/ubd_shifter.sv
module ubd_shifter
    import ubd_pkg::*;
#(
    parameter int W   = 32,
    parameter int SHL = 8
) (
    input  shift_e       sh,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    always_comb begin
        unique case (sh)
            SH_SRA1: dout = $unsigned($signed(din) >>> 1);
            SH_SLL8: dout = din << SHL;
            default: dout = din;
        endcase
    end
endmodule

// File: rtl/ubus_datapath.sv
module ubus_datapath
    import ubd_pkg::*;
#(
    parameter int W    = 32,
    parameter int NGEN = 8,
    parameter int BSW  = $clog2(NGEN + 3)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [5:0]      alu_ctl,
    input  logic [1:0]      shift_ctl,
    input  logic [NGEN:0]   wr_mask,
    input  logic [BSW-1:0]  b_sel,
    input  logic [W-1:0]    mem_word,
    input  logic [7:0]      mem_byte,
    output logic [W-1:0]    c_bus,
    output logic            n_flag,
    output logic            z_flag
);
    typedef struct packed {
        logic [NGEN-1:0][W-1:0] gen;
        logic [W-1:0]           hold;
    } dp_state_t;

    dp_state_t    state_d, state_q;
    logic [W-1:0] b_bus;
    logic [W-1:0] alu_res;
    logic [NGEN*W-1:0] gen_flat;

    assign gen_flat = state_q.gen;

    ubd_bsel #(.W(W), .NGEN(NGEN), .BSW(BSW)) u_bsel (
        .gen      (state_q.gen),
        .b_sel    (b_sel),
        .mem_word (mem_word),
        .mem_byte (mem_byte),
        .b_bus    (b_bus)
    );

    ubd_alu #(.W(W)) u_alu (
        .ctl  (alu_ctl_t'(alu_ctl)),
        .a_in (state_q.hold),
        .b_in (b_bus),
        .res  (alu_res),
        .neg  (n_flag),
        .zero (z_flag)
    );

    ubd_shifter #(.W(W)) u_shift (
        .sh   (shift_e'(shift_ctl)),
        .din  (alu_res),
        .dout (c_bus)
    );

    always_comb begin
        state_d = state_q;
        for (int i = 0; i < NGEN; i++) begin
            if (wr_mask[i]) state_d.gen[i] = c_bus;
        end
        if (wr_mask[NGEN]) state_d.hold = c_bus;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/ubd_checker.sv
module ubd_checker #(
    parameter int W    = 32,
    parameter int NGEN = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NGEN:0]     wr_mask,
    input logic [1:0]        shift_ctl,
    input logic [W-1:0]      c_bus,
    input logic              n_flag,
    input logic              z_flag,
    input logic [W-1:0]      alu_res,
    input logic [NGEN*W-1:0] gen_flat,
    input logic [W-1:0]      hold
);
    for (genvar g = 0; g < NGEN; g++) begin : g_reg
        AST_REG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_mask[g] |=> $stable(gen_flat[g*W +: W])); // R7
        AST_REG_CAPTURES: assert property (@(posedge clk) disable iff (!rst_n)
            wr_mask[g] |=> gen_flat[g*W +: W] == $past(c_bus)); // R8
    end

    AST_HOLD_CAPTURES: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mask[NGEN] |=> hold == $past(c_bus)); // R7
    AST_SHIFT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_ctl == 2'b00 || shift_ctl == 2'b11) |-> c_bus == alu_res); // R6
    AST_SHIFT_SRA_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        shift_ctl == 2'b01 |-> c_bus[W-1] == alu_res[W-1]); // R6
    AST_NEG_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        shift_ctl == 2'b00 |-> n_flag == c_bus[W-1]); // R9
    AST_ZERO_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        shift_ctl == 2'b00 |-> z_flag == (c_bus == '0)); // R10
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        z_flag |-> !n_flag); // R10
endmodule

bind ubus_datapath ubd_checker #(.W(W), .NGEN(NGEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_mask   (wr_mask),
    .shift_ctl (shift_ctl),
    .c_bus     (c_bus),
    .n_flag    (n_flag),
    .z_flag    (z_flag),
    .alu_res   (alu_res),
    .gen_flat  (gen_flat),
    .hold      (state_q.hold)
);

// File: tb/ubus_datapath_bench.sv
module ubus_datapath_bench;
    localparam int PERIOD = 10;
    localparam int W = 32;
    localparam int NGEN = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  alu_ctl = '0;
    logic [1:0]  shift_ctl = '0;
    logic [8:0]  wr_mask = '0;
    logic [3:0]  b_sel = '0;
    logic [31:0] mem_word = '0;
    logic [7:0]  mem_byte = '0;
    logic [31:0] c_bus;
    logic        n_flag, z_flag;

    int vectors = 0;
    int miscompares = 0;
    logic [31:0] m_gen [NGEN];
    logic [31:0] m_hold;

    always #(PERIOD/2) clk = ~clk;

    ubus_datapath u_ubus_datapath (
        .clk(clk), .rst_n(rst_n), .alu_ctl(alu_ctl), .shift_ctl(shift_ctl),
        .wr_mask(wr_mask), .b_sel(b_sel), .mem_word(mem_word),
        .mem_byte(mem_byte), .c_bus(c_bus), .n_flag(n_flag), .z_flag(z_flag)
    );

    // fn: 0 AND, 1 OR, 2 NOT B, 3 ADD
    function automatic logic [5:0] mk(input logic [1:0] fn, input logic ena,
                                      input logic enb, input logic inva, input logic inc);
        return {fn, ena, enb, inva, inc};
    endfunction

    function automatic logic [31:0] m_bsrc(input logic [3:0] s, input logic [31:0] w,
                                           input logic [7:0] y);
        if (s < 4'd8)       return m_gen[s[2:0]];
        else if (s == 4'd8) return w;
        else if (s == 4'd9) return {24'd0, y};
        else if (s == 4'd10) return {{24{y[7]}}, y};
        return 32'd0;
    endfunction

    function automatic logic [31:0] m_alu(input logic [5:0] c, input logic [31:0] b);
        logic [31:0] a, bb;
        a  = c[3] ? m_hold : 32'd0;
        if (c[1]) a = ~a;
        bb = c[2] ? b : 32'd0;
        case (c[5:4])
            2'b00:   return a & bb;
            2'b01:   return a | bb;
            2'b10:   return ~bb;
            default: return a + bb + {31'd0, c[0]};
        endcase
    endfunction

    function automatic logic [31:0] m_shift(input logic [1:0] s, input logic [31:0] x);
        case (s)
            2'b01:   return {x[31], x[31:1]};
            2'b10:   return x << 8;
            default: return x;
        endcase
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic [5:0] a, input logic [1:0] s, input logic [8:0] m,
                        input logic [3:0] b, input logic [31:0] w, input logic [7:0] y,
                        input string tag);
        logic [31:0] r, cx;
        @(negedge clk);
        alu_ctl = a; shift_ctl = s; wr_mask = m; b_sel = b; mem_word = w; mem_byte = y;
        #1;
        r  = m_alu(a, m_bsrc(b, w, y));
        cx = m_shift(s, r);
        check(tag, "c_bus", c_bus, cx);
        check(tag, "n_flag", {31'd0, n_flag}, {31'd0, r[31]});
        check(tag, "z_flag", {31'd0, z_flag}, {31'd0, (r == 32'd0)});
        @(posedge clk);
        for (int i = 0; i < NGEN; i++) if (m[i]) m_gen[i] = cx;
        if (m[8]) m_hold = cx;
    endtask

    initial begin
        #(PERIOD * 200000);
        miscompares++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < NGEN; i++) m_gen[i] = 32'd0;
        m_hold = 32'd0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset contents of every general register and of the holding register
        for (int i = 0; i < NGEN; i++) step(mk(1, 0, 1, 0, 0), 2'b00, 9'd0, 4'(i), 32'd0, 8'd0, "R1");
        step(mk(1, 1, 0, 0, 0), 2'b00, 9'd0, 4'd0, 32'd0, 8'd0, "R1");

        // R2: external sources and unused codes
        step(mk(1, 0, 1, 0, 0), 2'b00, 9'h001, 4'd8, 32'h0FF0_FFFF, 8'h9C, "R2");
        step(mk(1, 0, 1, 0, 0), 2'b00, 9'd0, 4'd9, 32'h1234_5678, 8'h9C, "R2");
        step(mk(1, 0, 1, 0, 0), 2'b00, 9'd0, 4'd10, 32'h1234_5678, 8'h9C, "R2");
        step(mk(1, 0, 1, 0, 0), 2'b00, 9'd0, 4'd10, 32'h1234_5678, 8'h5C, "R2");
        step(mk(1, 0, 1, 0, 0), 2'b00, 9'd0, 4'd13, 32'hFFFF_FFFF, 8'hFF, "R2");
        step(mk(1, 0, 1, 0, 0), 2'b00, 9'd0, 4'd0, 32'd0, 8'd0, "R2");

        // R7: load holding register, then several registers at once
        step(mk(1, 0, 1, 0, 0), 2'b00, 9'h100, 4'd8, 32'hF0F0_1234, 8'd0, "R7");
        step(mk(1, 0, 1, 0, 0), 2'b00, 9'h0A0, 4'd8, 32'hCAFE_0001, 8'd0, "R7");
        step(mk(1, 0, 1, 0, 0), 2'b00, 9'd0, 4'd5, 32'd0, 8'd0, "R7");
        step(mk(1, 0, 1, 0, 0), 2'b00, 9'd0, 4'd7, 32'd0, 8'd0, "R7");
        step(mk(1, 0, 1, 0, 0), 2'b00, 9'd0, 4'd6, 32'd0, 8'd0, "R7");

        // R3: logic functions, H against register 0
        step(mk(0, 1, 1, 0, 0), 2'b00, 9'd0, 4'd0, 32'd0, 8'd0, "R3");
        step(mk(1, 1, 1, 0, 0), 2'b00, 9'd0, 4'd0, 32'd0, 8'd0, "R3");
        step(mk(2, 1, 1, 0, 0), 2'b00, 9'd0, 4'd0, 32'd0, 8'd0, "R3");
        step(mk(3, 1, 1, 0, 0), 2'b00, 9'd0, 4'd0, 32'd0, 8'd0, "R3");

        // R4: negation of H and add with carry-in
        step(mk(3, 1, 0, 1, 1), 2'b00, 9'd0, 4'd0, 32'd0, 8'd0, "R4");
        step(mk(3, 1, 1, 0, 1), 2'b00, 9'd0, 4'd0, 32'd0, 8'd0, "R4");
        step(mk(1, 1, 0, 1, 1), 2'b00, 9'd0, 4'd0, 32'd0, 8'd0, "R4");

        // R5: gating
        step(mk(3, 0, 0, 0, 1), 2'b00, 9'd0, 4'd0, 32'd0, 8'd0, "R5");
        step(mk(1, 0, 0, 0, 0), 2'b00, 9'd0, 4'd0, 32'd0, 8'd0, "R5");
        step(mk(1, 1, 0, 0, 0), 2'b00, 9'd0, 4'd0, 32'd0, 8'd0, "R5");

        // R6: shifter codes on a negative H
        for (int s = 0; s < 4; s++) step(mk(1, 1, 0, 0, 0), 2'(s), 9'd0, 4'd0, 32'd0, 8'd0, "R6");

        // R8: register 2 incremented in place three times
        for (int k = 0; k < 3; k++) step(mk(3, 0, 1, 0, 1), 2'b00, 9'h004, 4'd2, 32'd0, 8'd0, "R8");
        step(mk(1, 0, 1, 0, 0), 2'b00, 9'd0, 4'd2, 32'd0, 8'd0, "R8");

        // R9 / R10: flags from the unshifted result
        step(mk(0, 0, 0, 0, 0), 2'b10, 9'd0, 4'd0, 32'd0, 8'd0, "R10");
        step(mk(2, 0, 0, 0, 0), 2'b10, 9'd0, 4'd0, 32'd0, 8'd0, "R9");
        step(mk(1, 0, 1, 0, 0), 2'b10, 9'd0, 4'd8, 32'h0100_0000, 8'd0, "R10");
        step(mk(1, 0, 1, 0, 0), 2'b01, 9'd0, 4'd8, 32'h0000_0001, 8'd0, "R9");

        // Random microinstructions across all fields (R2..R10)
        for (int n = 0; n < 3000; n++) begin
            step(6'($urandom), 2'($urandom), 9'($urandom), 4'($urandom),
                 $urandom, 8'($urandom), "R2-R10 random");
        end

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule